// File: doc/BRIEF.md
# Processor status trace port encoder

The encoder turns the per-cycle execution events of a processor core into a 4-bit status nibble for an external debug probe. Each cycle it drives exactly one status code, chosen by a fixed priority from the events present. Level conditions such as halt, stop, exception and debug-mode entry keep their code on the port for as long as they last.

The core can also hand over an operand of 1 to 4 bytes. The encoder queues it, announces it on the status nibble with a code that carries the byte count, and then streams it out on a separate 4-bit data nibble. A small queue absorbs operands that arrive while an earlier one is still being sent. When the queue is full, the encoder raises a stall request to the core.

A sample clock goes out with both nibbles. It is the processor clock inverted, so its rising edge falls in the middle of each cycle, while the nibbles are stable. A disable input turns all three outputs off and drops any queued or partly sent operand.

Top module: `trace_status_enc`

## Requirements
- R1: With no level condition and no operand pending, the status code on the cycle after an event is: pulse/write-debug-data start 4, taken branch or PC sync 5, return from exception 7, user-mode entry 3, instruction start 1. With no event the code is 0 (continue).
- R2: Halt, stop, debug-mode entry and exception are level inputs. They drive F, E, D and C respectively, one cycle later, on every cycle for as long as they are asserted.
- R3: When several events are present, the highest-priority one wins: halt, stop, debug entry, exception, operand announcement, branch, pulse, return from exception, user entry, instruction start. Lower-priority single-cycle events are dropped. A pending announcement waits for the first cycle with no level condition.
- R4: An operand is presented with op_valid_i, op_data_i and op_size_i, where op_size_i holds the byte count minus 1. The operand is announced with status code 8 + op_size_i, at the earliest two cycles after it is accepted.
- R5: Starting on the cycle after the announcement, the data nibble carries the operand least-significant nibble first, two nibbles per byte. At all other times the data nibble is 0, and the status nibble shows 0 unless another event occurs.
- R6: The next queued operand may be announced on the cycle in which the last nibble of the previous operand is on the data nibble, so the data stream has no gap.
- R7: Operands are queued up to DEPTH entries (default 2). stall_o is high exactly while the queue is full. An operand offered while stall_o is high is not accepted.
- R8: The reserved status codes 2 and 6 are never driven.
- R9: A disable_i high at a clock edge forces the status and data nibbles to 0 from that edge on. It also discards the queued and partly sent operands and ignores new operands while disable_i is high.
- R10: After reset, while the block is enabled, sclk_o equals the inverted processor clock. After an edge with disable_i high, and during reset, sclk_o is held low.
- R11: During reset, status_o, data_o and stall_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disable_i | input | 1 | Forces the trace outputs off and flushes operands |
| ev_halt_i | input | 1 | Core halted (level) |
| ev_stop_i | input | 1 | Core stopped, waiting for interrupt (level) |
| ev_dbg_i | input | 1 | Debug-mode entry exception processing (level) |
| ev_exc_i | input | 1 | Exception processing (level) |
| ev_branch_i | input | 1 | Taken branch or PC sync strobe |
| ev_pulse_i | input | 1 | Pulse or write-debug-data instruction start strobe |
| ev_rte_i | input | 1 | Return-from-exception instruction start strobe |
| ev_user_i | input | 1 | User-mode entry strobe |
| ev_insn_i | input | 1 | Instruction start strobe |
| op_valid_i | input | 1 | Operand offered this cycle |
| op_data_i | input | 32 | Operand bytes, least significant first on output |
| op_size_i | input | 2 | Byte count minus 1 |
| stall_o | output | 1 | Operand queue full, core must hold operands |
| status_o | output | 4 | Status nibble |
| data_o | output | 4 | Data nibble |
| sclk_o | output | 1 | Sample clock for the probe |

## Verification
The hardest case to reach is a full queue while a second operand is still being sent. At that point stall_o rises, and the next announcement must land exactly on the last nibble of the running operand. The stimulus gets there by offering three operands on consecutive cycles, with a short one first. The second and third then stack up behind it, and stall_o, the gapless hand-over and the code for the third size are each checked on their exact cycles. A second hard case is an announcement held off by a level condition, or beating a branch in the same cycle. This is reached by raising exception or branch on the cycle right after an operand is accepted.

// File: rtl/trace_enc_pkg.sv
package trace_enc_pkg;
  typedef enum logic [3:0] {
    ST_CONT   = 4'h0,
    ST_INSN   = 4'h1,
    ST_USER   = 4'h3,
    ST_PULSE  = 4'h4,
    ST_BRANCH = 4'h5,
    ST_RTE    = 4'h7,
    ST_XFER   = 4'h8,
    ST_EXC    = 4'hC,
    ST_DBG    = 4'hD,
    ST_STOP   = 4'hE,
    ST_HALT   = 4'hF
  } status_e;

  typedef struct packed {
    logic halt;
    logic stop;
    logic dbg;
    logic exc;
    logic branch;
    logic pulse;
    logic rte;
    logic user;
    logic insn;
  } events_t;
endpackage

// File: rtl/trace_op_fifo.sv
module trace_op_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/trace_nib_ser.sv
module trace_nib_ser #(
  parameter int OP_BYTES = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic                      load_i,
  input  logic [8*OP_BYTES-1:0]     data_i,
  input  logic [$clog2(OP_BYTES)-1:0] size_i,
  output logic [3:0]                nib_o,
  output logic                      free_o
);
  localparam int DW    = 8 * OP_BYTES;
  localparam int SZ_W  = $clog2(OP_BYTES);
  localparam int CNT_W = $clog2(2 * OP_BYTES + 1);

  logic [DW-1:0]    sh;
  logic [CNT_W-1:0] cnt;

  // free when idle or on the last nibble: lets the next operand follow without a gap
  assign free_o = (cnt <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh    <= '0;
      cnt   <= '0;
      nib_o <= '0;
    end else if (flush_i) begin
      sh    <= '0;
      cnt   <= '0;
      nib_o <= '0;
    end else begin
      nib_o <= (cnt != '0) ? sh[3:0] : 4'h0;
      if (load_i) begin
        sh  <= data_i;
        cnt <= CNT_W'({1'b0, size_i, 1'b0}) + CNT_W'(2);
      end else if (cnt != '0) begin
        sh  <= sh >> 4;
        cnt <= cnt - 1'b1;
      end
    end
  end

  if (SZ_W > CNT_W) begin : g_bad_size
    $error("size field wider than nibble counter");
  end
endmodule

// File: rtl/trace_prio_enc.sv
module trace_prio_enc
  import trace_enc_pkg::*;
#(
  parameter int SZ_W = 2
) (
  input  events_t          ev_i,
  input  logic             xfer_req_i,
  input  logic [SZ_W-1:0]  xfer_size_i,
  output logic [3:0]       code_o,
  output logic             xfer_grant_o
);
  always_comb begin
    xfer_grant_o = 1'b0;
    code_o       = 4'(ST_CONT);
    if      (ev_i.halt)   code_o = 4'(ST_HALT);
    else if (ev_i.stop)   code_o = 4'(ST_STOP);
    else if (ev_i.dbg)    code_o = 4'(ST_DBG);
    else if (ev_i.exc)    code_o = 4'(ST_EXC);
    else if (xfer_req_i) begin
      xfer_grant_o = 1'b1;
      code_o       = 4'(ST_XFER) | 4'(xfer_size_i);
    end
    else if (ev_i.branch) code_o = 4'(ST_BRANCH);
    else if (ev_i.pulse)  code_o = 4'(ST_PULSE);
    else if (ev_i.rte)    code_o = 4'(ST_RTE);
    else if (ev_i.user)   code_o = 4'(ST_USER);
    else if (ev_i.insn)   code_o = 4'(ST_INSN);
  end
endmodule

// File: rtl/trace_status_enc.sv
module trace_status_enc
  import trace_enc_pkg::*;
#(
  parameter int OP_BYTES = 4,
  parameter int DEPTH    = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      disable_i,
  input  logic                      ev_halt_i,
  input  logic                      ev_stop_i,
  input  logic                      ev_dbg_i,
  input  logic                      ev_exc_i,
  input  logic                      ev_branch_i,
  input  logic                      ev_pulse_i,
  input  logic                      ev_rte_i,
  input  logic                      ev_user_i,
  input  logic                      ev_insn_i,
  input  logic                      op_valid_i,
  input  logic [8*OP_BYTES-1:0]     op_data_i,
  input  logic [$clog2(OP_BYTES)-1:0] op_size_i,
  output logic                      stall_o,
  output logic [3:0]                status_o,
  output logic [3:0]                data_o,
  output logic                      sclk_o
);
  localparam int DW   = 8 * OP_BYTES;
  localparam int SZ_W = $clog2(OP_BYTES);
  localparam int FW   = SZ_W + DW;

  events_t       ev;
  logic [FW-1:0] q_head;
  logic          q_empty, q_full, ser_free, grant;
  logic [3:0]    code, status_q;
  logic          en_q;

  assign ev = '{halt: ev_halt_i, stop: ev_stop_i, dbg: ev_dbg_i, exc: ev_exc_i,
                branch: ev_branch_i, pulse: ev_pulse_i, rte: ev_rte_i,
                user: ev_user_i, insn: ev_insn_i};

  trace_op_fifo #(.W(FW), .DEPTH(DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (disable_i),
    .push_i  (op_valid_i),
    .din_i   ({op_size_i, op_data_i}),
    .pop_i   (grant),
    .dout_o  (q_head),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  trace_prio_enc #(.SZ_W(SZ_W)) i_prio (
    .ev_i         (ev),
    .xfer_req_i   (!q_empty && ser_free),
    .xfer_size_i  (q_head[FW-1 -: SZ_W]),
    .code_o       (code),
    .xfer_grant_o (grant)
  );

  trace_nib_ser #(.OP_BYTES(OP_BYTES)) i_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (disable_i),
    .load_i  (grant),
    .data_i  (q_head[DW-1:0]),
    .size_i  (q_head[FW-1 -: SZ_W]),
    .nib_o   (data_o),
    .free_o  (ser_free)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 4'h0;
      en_q     <= 1'b0;
    end else begin
      status_q <= disable_i ? 4'h0 : code;
      en_q     <= !disable_i;
    end
  end

  assign status_o = status_q;
  assign stall_o  = q_full;
  // en_q changes at the rising edge while ~clk_i is low: no glitch on the gated clock
  assign sclk_o   = ~clk_i & en_q;
endmodule

// File: rtl/trace_status_enc_chk.sv
module trace_status_enc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       disable_i,
  input logic       ev_halt_i,
  input logic       ev_stop_i,
  input logic       ev_dbg_i,
  input logic       ev_exc_i,
  input logic       op_valid_i,
  input logic       stall_o,
  input logic [3:0] status_o,
  input logic [3:0] data_o
);
  assert_reserved_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 4'h2) && (status_o != 4'h6));

  assert_halt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_halt_i && !disable_i) |=> (status_o == 4'hF));

  assert_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_stop_i && !ev_halt_i && !disable_i) |=> (status_o == 4'hE));

  assert_exc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_exc_i && !ev_dbg_i && !ev_stop_i && !ev_halt_i && !disable_i)
      |=> (status_o == 4'hC));

  assert_disable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> (status_o == 4'h0 && data_o == 4'h0 && !stall_o));

  assert_no_announce_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disable_i && !op_valid_i) |=> ##1 (status_o[3:2] != 2'b10));
endmodule

bind trace_status_enc trace_status_enc_chk i_chk (.*);

// File: tb/test_trace_status_enc.sv
module test_trace_status_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dis = 1'b0;
  logic [8:0]  ev = '0;
  logic        op_v = 1'b0;
  logic [31:0] op_d = '0;
  logic [1:0]  op_s = '0;
  logic        stall;
  logic [3:0]  st, dt;
  logic        sclk;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  trace_status_enc i_trace_status_enc (
    .clk_i(clk), .rst_ni(rst_n), .disable_i(dis),
    .ev_halt_i(ev[8]), .ev_stop_i(ev[7]), .ev_dbg_i(ev[6]), .ev_exc_i(ev[5]),
    .ev_branch_i(ev[4]), .ev_pulse_i(ev[3]), .ev_rte_i(ev[2]),
    .ev_user_i(ev[1]), .ev_insn_i(ev[0]),
    .op_valid_i(op_v), .op_data_i(op_d), .op_size_i(op_s),
    .stall_o(stall), .status_o(st), .data_o(dt), .sclk_o(sclk)
  );

  // events: halt stop dbg exc branch pulse rte user insn, then expected status
  localparam int NV = 17;
  localparam logic [12:0] VEC [NV] = '{
    {9'b000000000, 4'h0}, {9'b000000001, 4'h1}, {9'b000000010, 4'h3},
    {9'b000000100, 4'h7}, {9'b000001000, 4'h4}, {9'b000010000, 4'h5},
    {9'b000010001, 4'h5}, {9'b000001111, 4'h4}, {9'b000000111, 4'h7},
    {9'b000000011, 4'h3}, {9'b000100000, 4'hC}, {9'b001100000, 4'hD},
    {9'b010111111, 4'hE}, {9'b111111111, 4'hF}, {9'b100000000, 4'hF},
    {9'b000110000, 4'hC}, {9'b000000000, 4'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #2;
    chk("R11 status in reset", 32'(st), 0);
    chk("R11 data in reset", 32'(dt), 0);
    chk("R11 stall in reset", 32'(stall), 0);
    chk("R10 sclk in reset", 32'(sclk), 0);
    @(negedge clk); rst_n = 1'b1;
    step();
    #4; chk("R10 sclk enabled, clk low", 32'(sclk), 1);
    #4; #1; chk("R10 sclk enabled, clk high", 32'(sclk), 0);

    // R1 R2 R3 event table
    for (int i = 0; i < NV; i++) begin
      ev = VEC[i][12:4];
      step();
      if (st !== VEC[i][3:0]) begin
        n_cmp++; n_bad++;
        $display("FAIL R1/R2/R3 vec %0d: actual %0h expected %0h", i, st, VEC[i][3:0]);
      end else n_cmp++;
    end
    ev = '0; step();

    // R4 R5: single 4-byte operand
    op_v = 1'b1; op_d = 32'h8765_4321; op_s = 2'd3;
    step();
    op_v = 1'b0;
    step();
    chk("R4 announce 4 bytes", 32'(st), 32'hB);
    chk("R5 data idle on announce", 32'(dt), 0);
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R5 nibble", 32'(dt), 32'(i + 1));
      chk("R5 status continue", 32'(st), 0);
    end
    step();
    chk("R5 data after stream", 32'(dt), 0);

    // R6 R7: three operands back to back
    op_v = 1'b1; op_d = 32'h0000_00A5; op_s = 2'd0;
    step();
    op_d = 32'h0000_C3B2; op_s = 2'd1;
    step();
    chk("R4 announce 1 byte", 32'(st), 32'h8);
    chk("R7 stall with one queued", 32'(stall), 0);
    op_d = 32'h00F0_E1D2; op_s = 2'd2;
    step();
    op_v = 1'b0;
    chk("R5 first nibble", 32'(dt), 32'h5);
    chk("R7 stall when full", 32'(stall), 1);
    step();
    chk("R6 announce on last nibble", 32'(st), 32'h9);
    chk("R6 last nibble", 32'(dt), 32'hA);
    chk("R7 stall released", 32'(stall), 0);
    step(); chk("R5 nib", 32'(dt), 32'h2);
    step(); chk("R5 nib", 32'(dt), 32'hB);
    step(); chk("R5 nib", 32'(dt), 32'h3);
    step();
    chk("R6 second hand-over data", 32'(dt), 32'hC);
    chk("R4 announce 3 bytes", 32'(st), 32'hA);
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R5 3-byte nibble", 32'(dt), 32'((32'h00F0_E1D2 >> (4 * i)) & 32'hF));
    end
    step(); chk("R5 idle after", 32'(dt), 0);

    // R7: operand offered while full is not taken
    op_v = 1'b1; op_d = 32'h11; op_s = 2'd0; ev = 9'b100000000;
    step(); step(); step();
    chk("R7 full under halt", 32'(stall), 1);
    op_d = 32'h77;
    step();
    op_v = 1'b0; ev = '0;
    step(); chk("R3 announce after halt", 32'(st), 32'h8);
    step(); chk("R5 nib", 32'(dt), 32'h1);
    step(); chk("R5 nib", 32'(dt), 32'h1); chk("R6 second announce", 32'(st), 32'h8);
    step(); chk("R5 nib", 32'(dt), 32'h1);
    step(); chk("R7 rejected op not sent", 32'(dt), 32'h1); chk("R7 no third", 32'(st), 0);
    step(); chk("R7 stream ends", 32'(dt), 0);

    // R3: exception holds off announce; announce beats branch
    op_v = 1'b1; op_d = 32'h3C; op_s = 2'd0;
    step();
    op_v = 1'b0; ev = 9'b000110000;
    step(); chk("R3 exception over announce", 32'(st), 32'hC);
    ev = 9'b000010000;
    step(); chk("R3 announce over branch", 32'(st), 32'h8);
    ev = '0;
    step(); chk("R3 branch dropped", 32'(st), 0); chk("R5 nib", 32'(dt), 32'hC);
    step(); chk("R5 nib", 32'(dt), 32'h3);

    // R9 R10: disable mid-stream
    op_v = 1'b1; op_d = 32'hDEAD_BEEF; op_s = 2'd3;
    step();
    op_v = 1'b0;
    step(); chk("R4 announce", 32'(st), 32'hB);
    step(); chk("R5 nib", 32'(dt), 32'hF);
    dis = 1'b1; op_v = 1'b1; ev = 9'b000000001;
    step();
    chk("R9 status off", 32'(st), 0);
    chk("R9 data off", 32'(dt), 0);
    #4; chk("R10 sclk held low", 32'(sclk), 0);
    step();
    dis = 1'b0; op_v = 1'b0; ev = '0;
    step();
    chk("R9 flushed data", 32'(dt), 0);
    chk("R9 no announce", 32'(st), 0);
    #4; chk("R10 sclk back", 32'(sclk), 1);
    step(); chk("R9 still idle data", 32'(dt), 0); chk("R9 still idle status", 32'(st), 0);

    finish_run();
  end
endmodule